// File: doc/BRIEF.md
# Serial Port Clock and Frame-Sync Front End

This block sits between the pins of a synchronous serial port and the port's transmit and receive cores. For each direction it picks where the bit clock comes from: the pin, or the internal generator clock. It also picks where the frame sync comes from: the pin, or an internal source. It applies a per-signal polarity bit to every clock and sync pin and drives a registered output enable for each of those pins. Inside the block, every frame sync is active high.

All logic runs on one fast system clock `clk`. The bit clocks are treated as levels in that domain, and their rising and falling edges become one-cycle events. Incoming frame syncs and receive data are captured on the falling edge of the internal bit clock. Generated frame syncs and transmit data are launched on the rising edge. Each internal sync goes through an edge detector, which gives one start-of-frame pulse per active run. A loopback control sends the internal transmit sync and the transmit data into the receive side. A resynchronization control keeps the receive sync pin as an input, so the generator can align to it. Configuration is static while the port runs, and a change is followed by a reset.

Top module: `sp_fs_front`

## Requirements
- R1: With the transmit clock mode bit at 1, `clkx_oe` is 1 and the internal transmit clock is `gen_clk`. With the bit at 0, `clkx_oe` is 0 and the clock comes from `clkx_i`. `clkx_oe` follows the mode bit one `clk` cycle later.
- R2: In output mode, `clkx_o` equals `gen_clk` XOR the transmit clock polarity bit, delayed by one `clk` cycle.
- R3: In input mode, the internal transmit clock is `clkx_i` XOR the polarity bit. With polarity 1, a falling pin edge is an internal rising edge.
- R4: An externally driven frame sync is captured only on a falling edge of its own internal bit clock. While that clock holds still, pin changes have no effect.
- R5: Receive data (`dr_i`) is captured into `rx_bit` on the first `clk` edge after the internal receive clock falls. `rx_vld` is high for exactly that one cycle. A rising edge captures nothing.
- R6: `dx_o` takes `core_tx_bit` on the first `clk` edge after an internal transmit clock rise, and `tx_shift` pulses at the same edge. At all other times `dx_o` holds its value.
- R7: An input sync pin with polarity bit 1 is active low. It is inverted before use, so a low pin gives an active internal sync.
- R8: A generated sync is updated on internal clock rising edges. The pin shows the internal sync XOR the polarity bit, and its enable is 1.
- R9: In output mode, the transmit sync source bit chooses the source: 1 selects `gen_fs`, 0 selects `core_tx_fs`. The source that is not selected has no effect.
- R10: With `cfg_loop` at 1, the receive side uses the internal transmit sync in place of `fsr_i`, and receives `dx_o` in place of `dr_i`.
- R11: Each run of an active internal sync gives exactly one `rx_sof`/`tx_sof` pulse, one `clk` cycle after the internal level becomes active.
- R12: With `cfg_resync` at 1, `fsr_oe` is 0 and the receive sync is sampled from `fsr_i`, even when the receive sync mode bit selects the generator.
- R13: The receive clock controls (`cfg_rxclk_out`, `cfg_rxclk_inv`) behave exactly like the transmit clock controls, applied to `clkr_i`, `clkr_o` and `clkr_oe`.
- R14: While `rst_n` is low, every output enable, `dx_o`, `tx_shift`, `rx_vld`, `rx_sof` and `tx_sof` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_txclk_out | input | 1 | Transmit clock mode: 1 = generator clock driven out |
| cfg_txclk_inv | input | 1 | Transmit clock pin polarity |
| cfg_rxclk_out | input | 1 | Receive clock mode: 1 = generator clock driven out |
| cfg_rxclk_inv | input | 1 | Receive clock pin polarity |
| cfg_txfs_out | input | 1 | Transmit sync mode: 1 = internally generated |
| cfg_txfs_inv | input | 1 | Transmit sync pin polarity |
| cfg_txfs_src | input | 1 | Internal transmit sync source: 1 = gen_fs, 0 = core_tx_fs |
| cfg_rxfs_out | input | 1 | Receive sync mode: 1 = generator sync driven out |
| cfg_rxfs_inv | input | 1 | Receive sync pin polarity |
| cfg_resync | input | 1 | Keep receive sync pin as input for generator alignment |
| cfg_loop | input | 1 | Loopback of transmit sync and data into receive side |
| gen_clk | input | 1 | Internal generator bit clock level |
| gen_fs | input | 1 | Internal generator frame sync, active high |
| core_tx_fs | input | 1 | Frame sync request from transmit core, active high |
| core_tx_bit | input | 1 | Next transmit bit from transmit core |
| clkx_i | input | 1 | Transmit clock pin input |
| clkx_o | output | 1 | Transmit clock pin output |
| clkx_oe | output | 1 | Transmit clock pin enable |
| clkr_i | input | 1 | Receive clock pin input |
| clkr_o | output | 1 | Receive clock pin output |
| clkr_oe | output | 1 | Receive clock pin enable |
| fsx_i | input | 1 | Transmit sync pin input |
| fsx_o | output | 1 | Transmit sync pin output |
| fsx_oe | output | 1 | Transmit sync pin enable |
| fsr_i | input | 1 | Receive sync pin input |
| fsr_o | output | 1 | Receive sync pin output |
| fsr_oe | output | 1 | Receive sync pin enable |
| dr_i | input | 1 | Receive data pin |
| dx_o | output | 1 | Transmit data pin |
| tx_shift | output | 1 | One-cycle pulse when a transmit bit is launched |
| tx_sof | output | 1 | One-cycle transmit start-of-frame pulse |
| rx_bit | output | 1 | Last sampled receive bit |
| rx_vld | output | 1 | One-cycle pulse when rx_bit is captured |
| rx_sof | output | 1 | One-cycle receive start-of-frame pulse |

## Verification
Clock levels go straight into the edge detect, so a bit clock edge is turned into an event in the same `clk` cycle. Pin enables, `clkx_o`/`clkr_o`, `dx_o`, `tx_shift`, `rx_bit` and `rx_vld` are therefore due at the first `clk` edge after the stimulus. A sync pin shows its new level at the same edge as the launching clock rise, because the polarity XOR is applied after that register. `tx_sof`/`rx_sof` arrive one edge after the internal sync level changes, which is two edges after the bit clock edge that caused the change. The bench drives inputs 1 ns after each rising edge and samples at that same point after the following edge, so each single-edge result is checked in the exact cycle it is due. Start-of-frame pulses are counted over whole windows of bit clock periods, which checks both that one pulse occurs and that no extra pulse occurs.

// File: rtl/sp_fs_pkg.sv
package sp_fs_pkg;

    // Settings of one pin lane: drive direction and pin polarity
    typedef struct packed {
        logic drive_out;
        logic invert;
    } lane_cfg_t;

endpackage

// File: rtl/sp_clk_lane.sv
module sp_clk_lane
    import sp_fs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lane_cfg_t cfg,
    input  logic      gen_clk,
    input  logic      pin_i,
    output logic      pin_o,
    output logic      pin_oe,
    output logic      rise,
    output logic      fall
);

    typedef struct packed {
        logic prev;
        logic pin;
        logic oe;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    lvl;

    always_comb begin
        lvl        = cfg.drive_out ? gen_clk : (pin_i ^ cfg.invert);
        st_d.prev  = lvl;
        st_d.pin   = gen_clk ^ cfg.invert;
        st_d.oe    = cfg.drive_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise   = lvl & ~st_q.prev;
    assign fall   = ~lvl & st_q.prev;
    assign pin_o  = st_q.pin;
    assign pin_oe = st_q.oe;

endmodule

// File: rtl/sp_sync_lane.sv
module sp_sync_lane
    import sp_fs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lane_cfg_t cfg,
    input  logic      smp_evt,
    input  logic      gen_evt,
    input  logic      gen_fs,
    input  logic      pin_i,
    input  logic      ovr_en,
    input  logic      ovr_lvl,
    output logic      pin_o,
    output logic      pin_oe,
    output logic      lvl,
    output logic      sof
);

    typedef struct packed {
        logic smp;
        logic gen;
        logic prev;
        logic sof;
        logic oe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        if (smp_evt && !cfg.drive_out)
            st_d.smp = pin_i ^ cfg.invert;
        if (gen_evt && cfg.drive_out)
            st_d.gen = gen_fs;
        if (ovr_en)             lvl = ovr_lvl;
        else if (cfg.drive_out) lvl = st_q.gen;
        else                    lvl = st_q.smp;
        st_d.prev = lvl;
        st_d.sof  = lvl & ~st_q.prev;
        st_d.oe   = cfg.drive_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o  = st_q.gen ^ cfg.invert;
    assign pin_oe = st_q.oe;
    assign sof    = st_q.sof;

endmodule

// File: rtl/sp_fs_front.sv
module sp_fs_front
    import sp_fs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_txclk_out,
    input  logic cfg_txclk_inv,
    input  logic cfg_rxclk_out,
    input  logic cfg_rxclk_inv,
    input  logic cfg_txfs_out,
    input  logic cfg_txfs_inv,
    input  logic cfg_txfs_src,
    input  logic cfg_rxfs_out,
    input  logic cfg_rxfs_inv,
    input  logic cfg_resync,
    input  logic cfg_loop,
    input  logic gen_clk,
    input  logic gen_fs,
    input  logic core_tx_fs,
    input  logic core_tx_bit,
    input  logic clkx_i,
    output logic clkx_o,
    output logic clkx_oe,
    input  logic clkr_i,
    output logic clkr_o,
    output logic clkr_oe,
    input  logic fsx_i,
    output logic fsx_o,
    output logic fsx_oe,
    input  logic fsr_i,
    output logic fsr_o,
    output logic fsr_oe,
    input  logic dr_i,
    output logic dx_o,
    output logic tx_shift,
    output logic tx_sof,
    output logic rx_bit,
    output logic rx_vld,
    output logic rx_sof
);

    typedef struct packed {
        logic dx;
        logic shift;
        logic rbit;
        logic rvld;
    } dat_st_t;

    lane_cfg_t txclk_cfg, rxclk_cfg, txfs_cfg, rxfs_cfg;
    logic      tx_rise, tx_fall, rx_rise, rx_fall;
    logic      txfs_lvl, rxfs_lvl;
    logic      txfs_int_src;
    dat_st_t   dat_d, dat_q;

    always_comb begin
        txclk_cfg    = '{drive_out: cfg_txclk_out, invert: cfg_txclk_inv};
        rxclk_cfg    = '{drive_out: cfg_rxclk_out, invert: cfg_rxclk_inv};
        txfs_cfg     = '{drive_out: cfg_txfs_out,  invert: cfg_txfs_inv};
        // resync keeps the receive sync pin an input for generator alignment
        rxfs_cfg     = '{drive_out: cfg_rxfs_out & ~cfg_resync, invert: cfg_rxfs_inv};
        txfs_int_src = cfg_txfs_src ? gen_fs : core_tx_fs;
    end

    sp_clk_lane u_txclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (txclk_cfg),
        .gen_clk (gen_clk),
        .pin_i   (clkx_i),
        .pin_o   (clkx_o),
        .pin_oe  (clkx_oe),
        .rise    (tx_rise),
        .fall    (tx_fall)
    );

    sp_clk_lane u_rxclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (rxclk_cfg),
        .gen_clk (gen_clk),
        .pin_i   (clkr_i),
        .pin_o   (clkr_o),
        .pin_oe  (clkr_oe),
        .rise    (rx_rise),
        .fall    (rx_fall)
    );

    sp_sync_lane u_txfs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (txfs_cfg),
        .smp_evt (tx_fall),
        .gen_evt (tx_rise),
        .gen_fs  (txfs_int_src),
        .pin_i   (fsx_i),
        .ovr_en  (1'b0),
        .ovr_lvl (1'b0),
        .pin_o   (fsx_o),
        .pin_oe  (fsx_oe),
        .lvl     (txfs_lvl),
        .sof     (tx_sof)
    );

    sp_sync_lane u_rxfs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (rxfs_cfg),
        .smp_evt (rx_fall),
        .gen_evt (rx_rise),
        .gen_fs  (gen_fs),
        .pin_i   (fsr_i),
        .ovr_en  (cfg_loop),
        .ovr_lvl (txfs_lvl),
        .pin_o   (fsr_o),
        .pin_oe  (fsr_oe),
        .lvl     (rxfs_lvl),
        .sof     (rx_sof)
    );

    always_comb begin
        dat_d       = dat_q;
        dat_d.shift = tx_rise;
        dat_d.rvld  = rx_fall;
        if (tx_rise) dat_d.dx   = core_tx_bit;
        if (rx_fall) dat_d.rbit = cfg_loop ? dat_q.dx : dr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dat_q <= '0;
        else        dat_q <= dat_d;
    end

    assign dx_o     = dat_q.dx;
    assign tx_shift = dat_q.shift;
    assign rx_bit   = dat_q.rbit;
    assign rx_vld   = dat_q.rvld;

endmodule

module sp_fs_front_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_txclk_out,
    input logic cfg_txclk_inv,
    input logic cfg_rxclk_out,
    input logic cfg_resync,
    input logic gen_clk,
    input logic clkx_o,
    input logic clkx_oe,
    input logic clkr_oe,
    input logic fsr_oe,
    input logic dx_o,
    input logic tx_shift,
    input logic rx_vld,
    input logic rx_sof,
    input logic tx_sof
);

    // R1
    txclk_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (clkx_oe == $past(cfg_txclk_out)));

    // R2
    txclk_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_txclk_out)) |-> (clkx_o == ($past(gen_clk) ^ $past(cfg_txclk_inv))));

    // R13
    rxclk_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (clkr_oe == $past(cfg_rxclk_out)));

    // R6
    dx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (dx_o != $past(dx_o))) |-> tx_shift);

    // R5
    rx_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> !rx_vld);

    // R11
    rx_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sof |=> !rx_sof);

    // R11
    tx_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |=> !tx_sof);

    // R12
    resync_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_resync)) |-> !fsr_oe);

endmodule

bind sp_fs_front sp_fs_front_chk chk_i (.*);

// File: tb/sp_fs_front_tb.sv
`timescale 1ns/1ps
module sp_fs_front_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_txclk_out = 0, cfg_txclk_inv = 0, cfg_rxclk_out = 0, cfg_rxclk_inv = 0;
    logic cfg_txfs_out = 0, cfg_txfs_inv = 0, cfg_txfs_src = 0;
    logic cfg_rxfs_out = 0, cfg_rxfs_inv = 0, cfg_resync = 0, cfg_loop = 0;
    logic gen_clk = 0, gen_fs = 0, core_tx_fs = 0, core_tx_bit = 0;
    logic clkx_i = 0, clkr_i = 0, fsx_i = 0, fsr_i = 0, dr_i = 0;
    logic clkx_o, clkx_oe, clkr_o, clkr_oe, fsx_o, fsx_oe, fsr_o, fsr_oe;
    logic dx_o, tx_shift, tx_sof, rx_bit, rx_vld, rx_sof;

    int n_chk = 0;
    int n_fail = 0;
    int tx_sof_cnt = 0;
    int rx_sof_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sp_fs_front dut_i (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_cnt(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (tx_sof) tx_sof_cnt++;
        if (rx_sof) rx_sof_cnt++;
    endtask

    task automatic clr_cfg();
        cfg_txclk_out = 0; cfg_txclk_inv = 0; cfg_rxclk_out = 0; cfg_rxclk_inv = 0;
        cfg_txfs_out = 0; cfg_txfs_inv = 0; cfg_txfs_src = 0;
        cfg_rxfs_out = 0; cfg_rxfs_inv = 0; cfg_resync = 0; cfg_loop = 0;
        gen_clk = 0; gen_fs = 0; core_tx_fs = 0; core_tx_bit = 0;
        clkx_i = 0; clkr_i = 0; fsx_i = 0; fsr_i = 0; dr_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        step();
        step();
        rst_n = 1;
        tx_sof_cnt = 0;
        rx_sof_cnt = 0;
    endtask

    task automatic gen_cyc();
        gen_clk = 1; step();
        gen_clk = 0; step();
    endtask

    task automatic rx_cyc();
        clkr_i = 1; step();
        clkr_i = 0; step();
    endtask

    task automatic t_reset();
        clr_cfg();
        cfg_txclk_out = 1; cfg_rxclk_out = 1; cfg_txfs_out = 1; cfg_rxfs_out = 1;
        gen_clk = 1; core_tx_bit = 1;
        rst_n = 0;
        step();
        chk("R14 clkx_oe in reset", clkx_oe, 1'b0);
        chk("R14 fsx_oe in reset", fsx_oe, 1'b0);
        chk("R14 fsr_oe in reset", fsr_oe, 1'b0);
        chk("R14 dx_o in reset", dx_o, 1'b0);
        chk("R14 rx_vld in reset", rx_vld, 1'b0);
    endtask

    task automatic t_clk_out();
        clr_cfg();
        cfg_txclk_out = 1; cfg_txclk_inv = 1;
        cfg_rxclk_out = 0; cfg_rxclk_inv = 1;
        do_reset();
        gen_clk = 1; step();
        chk("R1 clkx_oe output mode", clkx_oe, 1'b1);
        chk("R2 clkx_o inverted high", clkx_o, 1'b0);
        chk("R13 clkr_oe input mode", clkr_oe, 1'b0);
        gen_clk = 0; step();
        chk("R2 clkx_o inverted low", clkx_o, 1'b1);
        // receive side mirrors: output mode without inversion
        clr_cfg();
        cfg_rxclk_out = 1;
        do_reset();
        gen_clk = 1; step();
        chk("R13 clkr_oe output mode", clkr_oe, 1'b1);
        chk("R13 clkr_o follows gen_clk", clkr_o, 1'b1);
    endtask

    task automatic t_tx_launch();
        clr_cfg();
        cfg_txclk_inv = 1; clkx_i = 1; core_tx_bit = 1;
        do_reset();
        step();
        chk("R1 clkx_oe input mode", clkx_oe, 1'b0);
        chk("R6 dx_o before any rise", dx_o, 1'b0);
        clkx_i = 0; step();
        chk("R3 inverted pin fall launches dx", dx_o, 1'b1);
        chk("R6 tx_shift pulse", tx_shift, 1'b1);
        core_tx_bit = 0; clkx_i = 1; step();
        chk("R6 dx_o holds on internal fall", dx_o, 1'b1);
        chk("R6 tx_shift low on fall", tx_shift, 1'b0);
    endtask

    task automatic t_rx_sample();
        clr_cfg();
        clkr_i = 1;
        do_reset();
        step();
        dr_i = 1; step();
        chk("R5 no capture while clock high", rx_vld, 1'b0);
        clkr_i = 0; step();
        chk("R5 rx_bit captured on fall", rx_bit, 1'b1);
        chk("R5 rx_vld pulse", rx_vld, 1'b1);
        step();
        chk("R5 rx_vld one cycle", rx_vld, 1'b0);
        dr_i = 0; clkr_i = 1; step();
        chk("R5 rise captures nothing", rx_bit, 1'b1);
    endtask

    task automatic t_rx_fs_ext();
        clr_cfg();
        cfg_rxfs_inv = 1; fsr_i = 1;
        do_reset();
        for (int i = 0; i < 3; i++) rx_cyc();
        chk_cnt("R7 inactive-high pin gives no sof", rx_sof_cnt, 0);
        clkr_i = 1; step();
        fsr_i = 0;
        for (int i = 0; i < 4; i++) step();
        chk_cnt("R4 no detect without falling edge", rx_sof_cnt, 0);
        for (int i = 0; i < 4; i++) rx_cyc();
        chk_cnt("R11 one sof for held low sync", rx_sof_cnt, 1);
        chk("R13 clkr_oe stays input", clkr_oe, 1'b0);
    endtask

    task automatic t_tx_fs_gen();
        clr_cfg();
        cfg_txclk_out = 1; cfg_txfs_out = 1; cfg_txfs_inv = 1; cfg_txfs_src = 1;
        gen_fs = 1; fsx_i = 1;
        do_reset();
        step();
        chk("R8 fsx_oe output mode", fsx_oe, 1'b1);
        chk("R8 fsx_o inactive inverted", fsx_o, 1'b1);
        gen_clk = 1; step();
        chk("R8 fsx_o active on rise", fsx_o, 1'b0);
        gen_clk = 0; step();
        for (int i = 0; i < 3; i++) gen_cyc();
        chk_cnt("R11 one tx_sof for held sync", tx_sof_cnt, 1);
        // core request source: generator sync must be ignored
        clr_cfg();
        cfg_txclk_out = 1; cfg_txfs_out = 1;
        gen_fs = 1;
        do_reset();
        for (int i = 0; i < 3; i++) gen_cyc();
        chk("R9 gen_fs ignored on pin", fsx_o, 1'b0);
        chk_cnt("R9 gen_fs ignored for sof", tx_sof_cnt, 0);
        core_tx_fs = 1;
        gen_cyc();
        chk("R9 core sync drives pin", fsx_o, 1'b1);
        core_tx_fs = 0;
        for (int i = 0; i < 2; i++) gen_cyc();
        chk_cnt("R9 core sync gives sof", tx_sof_cnt, 1);
    endtask

    task automatic t_loop();
        clr_cfg();
        cfg_loop = 1; cfg_txclk_out = 1; cfg_rxclk_out = 1; cfg_txfs_out = 1;
        fsr_i = 1; core_tx_bit = 1; dr_i = 0;
        do_reset();
        for (int i = 0; i < 4; i++) gen_cyc();
        chk_cnt("R10 fsr_i ignored in loopback", rx_sof_cnt, 0);
        chk("R10 rx data from dx", rx_bit, 1'b1);
        core_tx_fs = 1;
        gen_cyc();
        core_tx_fs = 0;
        for (int i = 0; i < 4; i++) gen_cyc();
        chk_cnt("R10 rx sof from tx sync", rx_sof_cnt, 1);
        chk_cnt("R10 tx sof count", tx_sof_cnt, 1);
    endtask

    task automatic t_resync();
        clr_cfg();
        cfg_rxfs_out = 1; cfg_resync = 1; fsr_i = 1;
        do_reset();
        step();
        chk("R12 fsr_oe off under resync", fsr_oe, 1'b0);
        for (int i = 0; i < 3; i++) rx_cyc();
        chk_cnt("R12 receive sync sampled from pin", rx_sof_cnt, 1);
        clr_cfg();
        cfg_rxfs_out = 1;
        do_reset();
        step();
        chk("R12 fsr_oe on without resync", fsr_oe, 1'b1);
    endtask

    initial begin
        t_reset();
        t_clk_out();
        t_tx_launch();
        t_rx_sample();
        t_rx_fs_ext();
        t_tx_fs_gen();
        t_loop();
        t_resync();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule